// File: doc/BRIEF.md
# Real-Time Clock Register File

This block is a small real-time clock reached through two byte locations on a register bus. Location 0 holds a pointer byte. Location 1 is a read window onto the internal register that the pointer selects. Inside, a binary 24-hour calendar tracks seconds, minutes, hours, weekday, day of month, month and a full binary year. The calendar advances once for every 32768 assertions of a crystal tick enable.

The time cannot be set from the bus. A preload port supplies the calendar value, and the block copies it in while reset is held. A controller selects a register by writing the pointer, then reads location 1. Writes to location 1 are dropped.

The status registers return fixed values. The one exception is an update-in-progress flag, which is high during the first eight tick periods of every second.

Top module: `rtc_regfile`

## Requirements
- R1: A write to location 0 stores all eight bits of the pointer. A read of location 0 returns that byte unchanged. After reset the pointer is 0x00.
- R2: Pointer bit 7 is stored but ignored. The window decodes only pointer bits 6:0, so pointer 0x80 reads the same value as pointer 0x00.
- R3: Window codes map to fields as follows: 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 weekday, 0x07 day, 0x08 month, 0x09 year mod 100, and 0x32 century. The century value is year/100 + 1, so the year 2025 reads 21.
- R4: The seconds field advances once per 32768 cycles with tick enable high. Cycles with tick enable low change neither the calendar nor the tick count.
- R5: Seconds wrap from 59 to 0, minutes from 59 to 0 and hours from 23 to 0, each wrap carrying into the next field. At each day change the weekday steps up, and it wraps from 7 (Saturday) to 1 (Sunday).
- R6: The day wraps to 1 after day 30 in April, June, September and November, and after day 31 in the other long months. When December rolls over, the month returns to 1 and the year increments.
- R7: February has 29 days when the year is divisible by 4, except for centuries that are not divisible by 400. Otherwise it has 28 days.
- R8: Window code 0x0A reads 0x26 in bits 6:0. Bit 7 is 1 while the tick count within the current second is below 8, and 0 for the rest of the second.
- R9: Window code 0x0B always reads 0x06, and window code 0x0D always reads 0x80.
- R10: Any other window code reads 0x00.
- R11: A write to location 1 changes neither the pointer nor the calendar.
- R12: While reset is high, the calendar loads from the preload port and the tick count clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the preload value |
| tick_en | input | 1 | 32768 Hz crystal tick enable, one cycle per tick |
| bus_addr | input | 1 | 0 selects the pointer, 1 selects the data window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location (combinational) |
| pl_sec | input | 6 | Preload seconds |
| pl_min | input | 6 | Preload minutes |
| pl_hour | input | 5 | Preload hours, 0 to 23 |
| pl_wday | input | 3 | Preload weekday, 1 = Sunday |
| pl_day | input | 5 | Preload day of month |
| pl_mon | input | 4 | Preload month, 1 to 12 |
| pl_year | input | 14 | Preload full binary year |

## Verification
Some properties are checked by assertions on every cycle. These cover the pointer holding or loading, the calendar and tick count freezing while tick enable is low, and every field staying within its legal range, including the day limit for the current month and year. They also cover the update flag rising only on a cycle where the calendar moved, and the fixed and zero status reads.

Other behaviour is shown only by the bench's scenarios, which run full seconds against a behavioural model. These scenarios cover the exact one-second period, the carry chain across a year end, the leap rules for 2000 and 2100, the April month length, weekday wrap, the century value, and preload under reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int YEAR_W = 14;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [3:0]        mon;
        logic [4:0]        day;
        logic [2:0]        wday;
        logic [4:0]        hour;
        logic [5:0]        min;
        logic [5:0]        sec;
    } cal_t;

    localparam logic [6:0] CODE_SEC  = 7'h00;
    localparam logic [6:0] CODE_MIN  = 7'h02;
    localparam logic [6:0] CODE_HOUR = 7'h04;
    localparam logic [6:0] CODE_WDAY = 7'h06;
    localparam logic [6:0] CODE_DAY  = 7'h07;
    localparam logic [6:0] CODE_MON  = 7'h08;
    localparam logic [6:0] CODE_YEAR = 7'h09;
    localparam logic [6:0] CODE_STA  = 7'h0A;
    localparam logic [6:0] CODE_STB  = 7'h0B;
    localparam logic [6:0] CODE_STD  = 7'h0D;
    localparam logic [6:0] CODE_CENT = 7'h32;

    localparam logic [6:0] STA_FIXED = 7'h26;
    localparam logic [7:0] STB_FIXED = 8'h06;
    localparam logic [7:0] STD_FIXED = 8'h80;

    function automatic logic leap_year(input logic [YEAR_W-1:0] y);
        logic by4, by100, by400;
        by4   = (y % YEAR_W'(4))   == '0;
        by100 = (y % YEAR_W'(100)) == '0;
        by400 = (y % YEAR_W'(400)) == '0;
        return (by4 && !by100) || by400;
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [YEAR_W-1:0] y);
        case (m)
            4'd2:                      return leap_year(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8,
    localparam int PRE_W        = $clog2(TICKS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic             sec_stb,
    output logic             uip,
    output logic [PRE_W-1:0] cnt
);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS_PER_SEC - 1);

    assign sec_stb = tick_en && (cnt == LAST);
    assign uip     = cnt < PRE_W'(UIP_TICKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= sec_stb ? '0 : cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sec_stb,
    input  cal_t preload,
    output cal_t cal_q
);
    cal_t nxt;

    always_comb begin
        nxt = cal_q;
        if (sec_stb) begin
            if (cal_q.sec != 6'd59) begin
                nxt.sec = cal_q.sec + 6'd1;
            end else begin
                nxt.sec = '0;
                if (cal_q.min != 6'd59) begin
                    nxt.min = cal_q.min + 6'd1;
                end else begin
                    nxt.min = '0;
                    if (cal_q.hour != 5'd23) begin
                        nxt.hour = cal_q.hour + 5'd1;
                    end else begin
                        nxt.hour = '0;
                        nxt.wday = (cal_q.wday == 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
                        if (cal_q.day != month_len(cal_q.mon, cal_q.year)) begin
                            nxt.day = cal_q.day + 5'd1;
                        end else begin
                            nxt.day = 5'd1;
                            if (cal_q.mon != 4'd12) begin
                                nxt.mon = cal_q.mon + 4'd1;
                            end else begin
                                nxt.mon  = 4'd1;
                                nxt.year = cal_q.year + YEAR_W'(1);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cal_q <= preload;
        else     cal_q <= nxt;
    end
endmodule

// File: rtl/rtc_window.sv
module rtc_window
    import rtc_pkg::*;
(
    input  logic [6:0] code,
    input  cal_t       cal,
    input  logic       uip,
    output logic [7:0] data
);
    logic [7:0] yr_lo;
    logic [7:0] cent;

    assign yr_lo = 8'(cal.year % YEAR_W'(100));
    assign cent  = 8'((cal.year / YEAR_W'(100)) + YEAR_W'(1));

    always_comb begin
        case (code)
            CODE_SEC:  data = {2'b00, cal.sec};
            CODE_MIN:  data = {2'b00, cal.min};
            CODE_HOUR: data = {3'b000, cal.hour};
            CODE_WDAY: data = {5'b00000, cal.wday};
            CODE_DAY:  data = {3'b000, cal.day};
            CODE_MON:  data = {4'b0000, cal.mon};
            CODE_YEAR: data = yr_lo;
            CODE_CENT: data = cent;
            CODE_STA:  data = {uip, STA_FIXED};
            CODE_STB:  data = STB_FIXED;
            CODE_STD:  data = STD_FIXED;
            default:   data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8,
    localparam int PRE_W        = $clog2(TICKS_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [5:0]        pl_sec,
    input  logic [5:0]        pl_min,
    input  logic [4:0]        pl_hour,
    input  logic [2:0]        pl_wday,
    input  logic [4:0]        pl_day,
    input  logic [3:0]        pl_mon,
    input  logic [YEAR_W-1:0] pl_year
);
    logic [7:0]       idx_q;
    logic             sec_stb;
    logic             uip;
    logic [PRE_W-1:0] presc_cnt;
    cal_t             preload;
    cal_t             cal_q;
    logic [7:0]       win_data;

    assign preload = '{year: pl_year, mon: pl_mon, day: pl_day, wday: pl_wday,
                       hour: pl_hour, min: pl_min, sec: pl_sec};

    always_ff @(posedge clk) begin
        if (rst)                      idx_q <= '0;
        else if (bus_wr && !bus_addr) idx_q <= bus_wdata;
    end

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_presc (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .sec_stb(sec_stb), .uip(uip), .cnt(presc_cnt)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst(rst), .sec_stb(sec_stb), .preload(preload), .cal_q(cal_q)
    );

    rtc_window u_win (
        .code(idx_q[6:0]), .cal(cal_q), .uip(uip), .data(win_data)
    );

    assign bus_rdata = bus_addr ? win_data : idx_q;
endmodule

// File: rtl/rtc_regfile_checks.sv
module rtc_regfile_checks
    import rtc_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             bus_addr,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic [7:0]       idx_q,
    input cal_t             cal,
    input logic [PRE_W-1:0] presc,
    input logic             uip
);
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_addr) |=> $stable(idx_q)); // R11
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr) |=> idx_q == $past(bus_wdata)); // R1
    AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(cal) && $stable(presc))); // R4
    AST_TIME_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cal.sec < 6'd60 && cal.min < 6'd60 && cal.hour < 5'd24
         && cal.wday >= 3'd1 && cal.wday <= 3'd7)); // R5
    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cal.mon >= 4'd1 && cal.mon <= 4'd12 && cal.day >= 5'd1
         && cal.day <= month_len(cal.mon, cal.year))); // R7
    AST_UIP_ON_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        $rose(uip) |-> (cal != $past(cal))); // R8
    AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (rst)
        (bus_addr && idx_q[6:0] == 7'h0B) |-> bus_rdata == 8'h06); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr && idx_q[6:0] == 7'h01) |-> bus_rdata == 8'h00); // R10
endmodule

bind rtc_regfile rtc_regfile_checks #(.PRE_W(PRE_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idx_q(idx_q), .cal(cal_q),
    .presc(presc_cnt), .uip(uip)
);

// File: tb/sim_rtc_regfile.sv
`timescale 1ns/1ps
module sim_rtc_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [5:0]  pl_sec = '0;
    logic [5:0]  pl_min = '0;
    logic [4:0]  pl_hour = '0;
    logic [2:0]  pl_wday = 3'd1;
    logic [4:0]  pl_day = 5'd1;
    logic [3:0]  pl_mon = 4'd1;
    logic [13:0] pl_year = 14'd2000;

    int total = 0, bad = 0, cyc = 0;
    bit model_on = 0;

    // behavioural model state
    int m_sec, m_min, m_hour, m_wday, m_day, m_mon, m_year, m_presc, m_idx;

    always #10 clk = ~clk;

    rtc_regfile u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pl_sec(pl_sec), .pl_min(pl_min),
        .pl_hour(pl_hour), .pl_wday(pl_wday), .pl_day(pl_day), .pl_mon(pl_mon),
        .pl_year(pl_year)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_days(input int mo, input int y);
        bit lp;
        lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int m_read();
        if (!bus_addr) return m_idx;
        case (m_idx % 128)
            'h00: return m_sec;
            'h02: return m_min;
            'h04: return m_hour;
            'h06: return m_wday;
            'h07: return m_day;
            'h08: return m_mon;
            'h09: return m_year % 100;
            'h32: return m_year / 100 + 1;
            'h0A: return (m_presc < 8 ? 'h80 : 0) + 'h26;
            'h0B: return 'h06;
            'h0D: return 'h80;
            default: return 0;
        endcase
    endfunction

    function automatic string m_tag();
        if (!bus_addr) return "R1";
        case (m_idx % 128)
            'h0A: return "R8";
            'h0B, 'h0D: return "R9";
            'h00, 'h02, 'h04, 'h06, 'h07, 'h08, 'h09, 'h32: return "R3";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_sec = pl_sec; m_min = pl_min; m_hour = pl_hour; m_wday = pl_wday;
            m_day = pl_day; m_mon = pl_mon; m_year = pl_year; m_presc = 0; m_idx = 0;
        end else begin
            if (bus_wr && !bus_addr) m_idx = bus_wdata;
            if (tick_en) begin
                m_presc++;
                if (m_presc == 32768) begin
                    m_presc = 0;
                    m_sec++;
                    if (m_sec == 60) begin
                        m_sec = 0; m_min++;
                        if (m_min == 60) begin
                            m_min = 0; m_hour++;
                            if (m_hour == 24) begin
                                m_hour = 0;
                                m_wday = (m_wday % 7) + 1;
                                m_day++;
                                if (m_day > m_days(m_mon, m_year)) begin
                                    m_day = 1; m_mon++;
                                    if (m_mon == 13) begin m_mon = 1; m_year++; end
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model, before inputs move
    always @(negedge clk) begin
        if (model_on && !rst) chk(m_tag(), bus_rdata, m_read(), "model compare");
    end

    always @(posedge clk) begin
        if (cyc == 195000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=<195000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic read_reg(input logic [7:0] code, output int val);
        @(negedge clk); #1;
        bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = code;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = 1'b1;
        #3 val = bus_rdata;
    endtask

    task automatic start(input int y, input int mo, input int d, input int wd,
                         input int h, input int mi, input int s);
        model_on = 0;
        @(negedge clk); #1;
        rst = 1'b1; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0;
        pl_year = 14'(y); pl_mon = 4'(mo); pl_day = 5'(d); pl_wday = 3'(wd);
        pl_hour = 5'(h); pl_min = 6'(mi); pl_sec = 6'(s);
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
        #3 chk("R12", bus_rdata, 0, "pointer after reset");
        model_on = 1;
    endtask

    task automatic run(input int ncyc, input int gate);
        logic [7:0] codes [14] = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h07, 8'h08, 8'h09,
                                   8'h32, 8'h0A, 8'h0B, 8'h0D, 8'h01, 8'h7F, 8'h05};
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk); #1;
            tick_en = (gate == 0) ? 1'b1 : ((k % gate) != 0);
            case (k % 4)
                0: begin
                    bus_addr = 1'b0; bus_wr = 1'b1;
                    bus_wdata = codes[(k / 4) % 14] | (((k % 8) == 0) ? 8'h80 : 8'h00);
                end
                3: begin bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'(k); end
                default: begin bus_addr = 1'b1; bus_wr = 1'b0; end
            endcase
        end
        @(negedge clk); #1;
        tick_en = 1'b0; bus_wr = 1'b0; bus_addr = 1'b1;
    endtask

    task automatic date_check(input string req, input int y2, input int cent, input int mo,
                              input int d, input int wd, input int h, input int mi, input int s);
        int v;
        read_reg(8'h00, v); chk(req, v, s, "seconds");
        read_reg(8'h02, v); chk(req, v, mi, "minutes");
        read_reg(8'h04, v); chk(req, v, h, "hours");
        read_reg(8'h06, v); chk(req, v, wd, "weekday");
        read_reg(8'h07, v); chk(req, v, d, "day");
        read_reg(8'h08, v); chk(req, v, mo, "month");
        read_reg(8'h09, v); chk("R3", v, y2, "year mod 100");
        read_reg(8'h32, v); chk("R3", v, cent, "century");
    endtask

    initial begin
        int v;
        // scenario 1: year-end carry chain, weekday 7 -> 1
        start(1999, 12, 31, 7, 23, 59, 59);
        read_reg(8'h00, v); chk("R12", v, 59, "preloaded seconds");
        read_reg(8'h0A, v); chk("R8", v, 'hA6, "update flag right after reset");
        read_reg(8'h0B, v); chk("R9", v, 'h06, "status B");
        read_reg(8'h0D, v); chk("R9", v, 'h80, "status D");
        read_reg(8'h01, v); chk("R10", v, 0, "unmapped 0x01");
        read_reg(8'h7F, v); chk("R10", v, 0, "unmapped 0x7F");
        read_reg(8'h80, v); chk("R2", v, 59, "bit7 set reads seconds");
        bus_addr = 1'b0; #3 chk("R1", bus_rdata, 'h80, "pointer keeps bit 7");
        @(negedge clk); #1 bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h11;
        @(negedge clk); #1 bus_wr = 1'b0; bus_addr = 1'b0;
        #3 chk("R11", bus_rdata, 'h80, "pointer after data write");
        read_reg(8'h00, v); chk("R11", v, 59, "seconds after data write");
        run(32768 + 20, 0);
        date_check("R5", 0, 21, 1, 1, 1, 0, 0, 0);
        read_reg(8'h0A, v); chk("R8", v, 'h26, "update flag late in second");

        // scenario 2: leap February in a year divisible by 400
        start(2000, 2, 28, 2, 23, 59, 59);
        run(32768 + 20, 0);
        date_check("R7", 0, 21, 2, 29, 3, 0, 0, 0);

        // scenario 3: century year that is not a leap year
        start(2100, 2, 28, 1, 23, 59, 59);
        run(32768 + 20, 0);
        date_check("R7", 0, 22, 3, 1, 2, 0, 0, 0);

        // scenario 4: 30-day month with gated tick enable
        start(2025, 4, 30, 4, 23, 59, 59);
        read_reg(8'h32, v); chk("R3", v, 21, "century for 2025");
        run(40980, 5);
        date_check("R6", 25, 21, 5, 1, 5, 0, 0, 0);
        read_reg(8'h00, v); chk("R4", v, 0, "seconds held with tick low");

        model_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule